// File: doc/BRIEF.md
# TCP Splice Sequence Translator

This block sits in the forwarding datapath of a content-aware switch. The switch first completes its own handshake with a client, using the switch's initial sequence number D. It then opens a second connection to a chosen server that reuses the client's initial number C, and the server answers with its own initial number S. Once the two connections are joined, every segment that crosses the switch must have its numbering rewritten so that each endpoint sees one continuous stream. A client segment acknowledging D+k leaves toward the server acknowledging S+k. A server segment carrying sequence S+k leaves toward the client carrying D+k. Numbers in the client's sequence space pass through untouched in both directions, because both connections start from C.

A table of splice entries is indexed by connection number. Each entry holds a valid bit and the offset S−D, computed modulo 2^32 when the entry is written. Parsed header fields enter with a direction bit and a connection number. The translated fields leave one registered stage later. Both sides of that stage use valid/ready handshaking. A segment that arrives for a connection with no valid entry leaves unchanged, with a miss flag set.

Top module: `tcp_splice_xlate`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and every table entry is invalid, so a segment sent before any configuration write leaves with out_miss = 1.
- R2: A client-to-server segment (in_dir = 0) with in_ack_flag = 1 on a valid entry leaves with out_ack = in_ack + (S − D) mod 2^32, with out_seq = in_seq and out_miss = 0.
- R3: A client-to-server segment with in_ack_flag = 0 leaves with out_ack = in_ack and out_seq = in_seq.
- R4: A server-to-client segment (in_dir = 1) on a valid entry leaves with out_seq = in_seq − (S − D) mod 2^32, and out_ack = in_ack whatever the value of in_ack_flag.
- R5: A segment whose entry is invalid leaves with out_seq and out_ack equal to the input values and out_miss = 1.
- R6: Offsets and rewrites wrap modulo 2^32; for example, D = 0xFFFFFFF0 and S = 0x00000010 map a client acknowledgment of 0x00000010 to 0x00000030.
- R7: A segment is taken when in_valid and in_ready are both 1, and in_ready = !out_valid || out_ready. The result appears on the output the following cycle. While out_valid = 1 and out_ready = 0, all outputs hold steady. No segment is lost or duplicated.
- R8: A configuration write (cfg_we = 1) sets entry cfg_idx to valid with offset cfg_srv_isn − cfg_sw_isn when cfg_set = 1, and clears it when cfg_set = 0. It affects only segments taken in later cycles; a segment taken in the same cycle sees the previous entry.
- R9: out_dir, out_conn and out_ack_flag equal the in_dir, in_conn and in_ack_flag of the same segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Entry written |
| cfg_set | input | 1 | 1 = make entry valid, 0 = clear it |
| cfg_sw_isn | input | 32 | Switch initial sequence number D |
| cfg_srv_isn | input | 32 | Server initial sequence number S |
| in_valid | input | 1 | Input segment present |
| in_ready | output | 1 | Stage can take a segment |
| in_dir | input | 1 | 0 = client to server, 1 = server to client |
| in_conn | input | 4 | Connection number |
| in_seq | input | 32 | Sequence number field |
| in_ack | input | 32 | Acknowledgment number field |
| in_ack_flag | input | 1 | Acknowledgment field is meaningful |
| out_valid | output | 1 | Output segment present |
| out_ready | input | 1 | Downstream accepts the segment |
| out_dir | output | 1 | Direction of the segment |
| out_conn | output | 4 | Connection number |
| out_seq | output | 32 | Rewritten sequence number |
| out_ack | output | 32 | Rewritten acknowledgment number |
| out_ack_flag | output | 1 | Acknowledgment flag, passed through |
| out_miss | output | 1 | Entry was invalid; fields left unchanged |

## Verification
Two functions can act in the same cycle: a table write and a lookup of that same entry. The bench provokes this by driving the write and a segment on the same connection in one cycle while the stage is empty and downstream is ready, so the segment is certain to be taken. The segment is judged against the entry as it was before the write. It is expected to miss when the entry was previously invalid, and the segment that follows must see the new offset. The random phase also interleaves writes with traffic under random downstream stalls, and each result is compared with a reference model that applies writes only after the lookup of that cycle.

// File: rtl/splice_pkg.sv
// Shared types for the TCP splice translator.
// Assumes: the direction bit is 0 for client-to-server and 1 for server-to-client.
package splice_pkg;
    typedef enum logic {
        DIR_C2S = 1'b0,
        DIR_S2C = 1'b1
    } dir_e;
endpackage

// File: rtl/splice_table.sv
// Splice entry table: one valid bit and one modular offset (server ISN minus
// switch ISN) per connection. Assumes a single write port and one combinational
// read port; a write becomes visible to the read port one cycle later.
module splice_table #(
    parameter int SEQ_W   = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_set,
    input  logic [SEQ_W-1:0] wr_sw_isn,
    input  logic [SEQ_W-1:0] wr_srv_isn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit,
    output logic [SEQ_W-1:0] rd_delta
);
    logic [ENTRIES-1:0] valid_q;
    logic [SEQ_W-1:0]   delta_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Update the valid bit of this entry on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid_q[e] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(e))
                valid_q[e] <= wr_set;
        end

        // Store the modular offset when this entry is made valid.
        always_ff @(posedge clk) begin
            if (wr_en && wr_set && wr_idx == IDX_W'(e))
                delta_q[e] <= wr_srv_isn - wr_sw_isn;
        end
    end

    // Read port: the old contents, so a write in the same cycle is not seen.
    assign rd_hit   = valid_q[rd_idx];
    assign rd_delta = delta_q[rd_idx];

    // R8: a write leaves the entry in the state requested.
    a_r8_write_applies: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)] == $past(wr_set));
    // R1: reset clears every entry.
    a_r1_table_cleared: assert property (@(posedge clk)
        !rst_n |=> valid_q == '0);
endmodule

// File: rtl/splice_rewrite.sv
// Combinational rewrite of one segment's numbers from the looked-up entry.
// Client-to-server: the acknowledgment moves from switch space to server space
// (only when the ack flag is set). Server-to-client: the sequence moves from
// server space to switch space. A missing entry leaves both fields unchanged.
module splice_rewrite
    import splice_pkg::*;
#(
    parameter int SEQ_W = 32
) (
    input  dir_e             dir,
    input  logic             hit,
    input  logic [SEQ_W-1:0] delta,
    input  logic             ack_flag,
    input  logic [SEQ_W-1:0] seq_in,
    input  logic [SEQ_W-1:0] ack_in,
    output logic [SEQ_W-1:0] seq_out,
    output logic [SEQ_W-1:0] ack_out,
    output logic             miss
);
    // Select which field is offset, and in which sense, for this direction.
    always_comb begin
        seq_out = seq_in;
        ack_out = ack_in;
        miss    = !hit;
        if (hit) begin
            if (dir == DIR_C2S) begin
                if (ack_flag)
                    ack_out = ack_in + delta;
            end else begin
                seq_out = seq_in - delta;
            end
        end
    end
endmodule

// File: rtl/splice_stage.sv
// One registered pipeline stage with valid/ready handshake on both sides.
// Assumes the payload is opaque; it holds while the output is stalled.
module splice_stage #(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    // Track occupancy: refill when the slot frees, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Capture the payload on a transfer into the stage.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready)
            out_data <= in_data;
    end

    // R7: a stalled output stays present and unchanged.
    a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R7: a taken input is presented on the next cycle.
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    // R1: reset empties the stage.
    a_r1_stage_empty: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: rtl/tcp_splice_xlate.sv
// TCP splice sequence translator. It looks up the splice entry of each segment,
// rewrites the acknowledgment (client to server) or the sequence (server to
// client) by the stored modular offset, and presents the result one registered
// stage later. Assumes header parsing and checksum repair happen elsewhere.
module tcp_splice_xlate
    import splice_pkg::*;
#(
    parameter int SEQ_W   = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_set,
    input  logic [SEQ_W-1:0] cfg_sw_isn,
    input  logic [SEQ_W-1:0] cfg_srv_isn,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dir,
    input  logic [IDX_W-1:0] in_conn,
    input  logic [SEQ_W-1:0] in_seq,
    input  logic [SEQ_W-1:0] in_ack,
    input  logic             in_ack_flag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_dir,
    output logic [IDX_W-1:0] out_conn,
    output logic [SEQ_W-1:0] out_seq,
    output logic [SEQ_W-1:0] out_ack,
    output logic             out_ack_flag,
    output logic             out_miss
);
    typedef struct packed {
        logic             dir;
        logic [IDX_W-1:0] conn;
        logic [SEQ_W-1:0] seq;
        logic [SEQ_W-1:0] ack;
        logic             ack_flag;
        logic             miss;
    } seg_t;

    logic             tbl_hit;
    logic [SEQ_W-1:0] tbl_delta;
    logic [SEQ_W-1:0] rw_seq;
    logic [SEQ_W-1:0] rw_ack;
    logic             rw_miss;
    seg_t             stage_in;
    seg_t             stage_out;

    splice_table #(.SEQ_W(SEQ_W), .ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_set     (cfg_set),
        .wr_sw_isn  (cfg_sw_isn),
        .wr_srv_isn (cfg_srv_isn),
        .rd_idx     (in_conn),
        .rd_hit     (tbl_hit),
        .rd_delta   (tbl_delta)
    );

    splice_rewrite #(.SEQ_W(SEQ_W)) u_rewrite (
        .dir      (dir_e'(in_dir)),
        .hit      (tbl_hit),
        .delta    (tbl_delta),
        .ack_flag (in_ack_flag),
        .seq_in   (in_seq),
        .ack_in   (in_ack),
        .seq_out  (rw_seq),
        .ack_out  (rw_ack),
        .miss     (rw_miss)
    );

    // Gather the rewritten segment into the stage payload.
    always_comb begin
        stage_in.dir      = in_dir;
        stage_in.conn     = in_conn;
        stage_in.seq      = rw_seq;
        stage_in.ack      = rw_ack;
        stage_in.ack_flag = in_ack_flag;
        stage_in.miss     = rw_miss;
    end

    splice_stage #(.PAY_W($bits(seg_t))) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (stage_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (stage_out)
    );

    assign out_dir      = stage_out.dir;
    assign out_conn     = stage_out.conn;
    assign out_seq      = stage_out.seq;
    assign out_ack      = stage_out.ack;
    assign out_ack_flag = stage_out.ack_flag;
    assign out_miss     = stage_out.miss;

    // R2: a client acknowledgment moves into server space; the sequence is untouched.
    a_r2_c2s_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dir == DIR_C2S && in_ack_flag && tbl_hit) |=>
        (out_ack - $past(tbl_delta) == $past(in_ack) && out_seq == $past(in_seq) && !out_miss));
    // R3: without the ack flag nothing is rewritten on the client path.
    a_r3_no_ack_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dir == DIR_C2S && !in_ack_flag) |=>
        (out_ack == $past(in_ack) && out_seq == $past(in_seq)));
    // R4: a server sequence moves into switch space; the acknowledgment is untouched.
    a_r4_s2c_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dir == DIR_S2C && tbl_hit) |=>
        (out_seq + $past(tbl_delta) == $past(in_seq) && out_ack == $past(in_ack)));
    // R5: a missing entry passes the segment through and flags it.
    a_r5_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !tbl_hit) |=>
        (out_miss && out_seq == $past(in_seq) && out_ack == $past(in_ack)));
    // R9: side fields travel with the segment.
    a_r9_side_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=>
        (out_dir == $past(in_dir) && out_conn == $past(in_conn) && out_ack_flag == $past(in_ack_flag)));
endmodule

// File: tb/sim_tcp_splice_xlate.sv
`timescale 1ns/1ps
module sim_tcp_splice_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic        cfg_set = 1'b0;
    logic [31:0] cfg_sw_isn = '0;
    logic [31:0] cfg_srv_isn = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_dir = 1'b0;
    logic [3:0]  in_conn = '0;
    logic [31:0] in_seq = '0;
    logic [31:0] in_ack = '0;
    logic        in_ack_flag = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_dir;
    logic [3:0]  out_conn;
    logic [31:0] out_seq;
    logic [31:0] out_ack;
    logic        out_ack_flag;
    logic        out_miss;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit rdy_rand = 1'b0;

    always #2.5 clk = ~clk;

    tcp_splice_xlate u0 (.*);

    // Reference model state
    bit          m_valid [16];
    logic [31:0] m_d [16];
    logic [31:0] m_s [16];
    bit          any_cfg = 1'b0;

    typedef struct packed {
        logic        dir;
        logic [3:0]  conn;
        logic [31:0] seq;
        logic [31:0] ack;
        logic        ackf;
        logic        miss;
        logic [3:0]  tag;
    } exp_t;
    exp_t q[$];

    bit          hold_pend = 1'b0;
    logic [71:0] hold_val;

    function automatic string tag_name(logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd8: return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [71:0] act, logic [71:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Cycle-by-cycle reference model, evaluated mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            logic [31:0] dl;
            // R7: readiness follows output occupancy
            chk(in_ready == (!out_valid || out_ready), "R7", 72'(in_ready), 72'(!out_valid || out_ready));
            // R7: stall holds outputs
            if (hold_pend)
                chk({out_valid, out_dir, out_conn, out_seq, out_ack, out_ack_flag, out_miss} == hold_val,
                    "R7", {out_valid, out_dir, out_conn, out_seq, out_ack, out_ack_flag, out_miss}, hold_val);
            hold_pend = out_valid && !out_ready;
            hold_val  = {out_valid, out_dir, out_conn, out_seq, out_ack, out_ack_flag, out_miss};
            // Output transfer: compare against the oldest expected segment
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", 72'(out_seq), 72'(0));
                end else begin
                    e = q.pop_front();
                    chk(out_seq == e.seq, tag_name(e.tag), 72'(out_seq), 72'(e.seq));
                    chk(out_ack == e.ack, tag_name(e.tag), 72'(out_ack), 72'(e.ack));
                    chk(out_miss == e.miss, tag_name(e.tag), 72'(out_miss), 72'(e.miss));
                    chk({out_dir, out_conn, out_ack_flag} == {e.dir, e.conn, e.ackf}, "R9",
                        72'({out_dir, out_conn, out_ack_flag}), 72'({e.dir, e.conn, e.ackf}));
                end
            end
            // Input transfer: expected result from the table before this cycle's write
            if (in_valid && in_ready) begin
                e.dir = in_dir; e.conn = in_conn; e.ackf = in_ack_flag;
                e.seq = in_seq; e.ack = in_ack; e.miss = !m_valid[in_conn];
                dl = m_s[in_conn] - m_d[in_conn];
                if (m_valid[in_conn]) begin
                    if (in_dir == 1'b0) begin
                        if (in_ack_flag) e.ack = in_ack + dl;
                    end else begin
                        e.seq = in_seq - dl;
                    end
                end
                if (cfg_we && cfg_idx == in_conn) e.tag = 4'd8;
                else if (!any_cfg)                e.tag = 4'd1;
                else if (e.miss)                  e.tag = 4'd5;
                else if (in_conn == 4'd2)         e.tag = 4'd6;
                else if (in_dir)                  e.tag = 4'd4;
                else if (in_ack_flag)             e.tag = 4'd2;
                else                              e.tag = 4'd3;
                q.push_back(e);
            end
            if (cfg_we) begin
                any_cfg = 1'b1;
                m_valid[cfg_idx] = cfg_set;
                if (cfg_set) begin
                    m_d[cfg_idx] = cfg_sw_isn;
                    m_s[cfg_idx] = cfg_srv_isn;
                end
            end
        end
    end

    // Downstream readiness: steady or random.
    always @(posedge clk) begin
        #1;
        out_ready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg(logic [3:0] idx, bit set, logic [31:0] d, logic [31:0] s);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = idx; cfg_set = set; cfg_sw_isn = d; cfg_srv_isn = s;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic send(bit dir, logic [3:0] conn, logic [31:0] seq, logic [31:0] ack, bit ackf);
        bit taken;
        @(posedge clk); #1;
        in_valid = 1'b1; in_dir = dir; in_conn = conn; in_seq = seq; in_ack = ack; in_ack_flag = ackf;
        do begin
            @(negedge clk);
            taken = in_ready;
            @(posedge clk); #1;
        end while (!taken);
        in_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_d[i] = '0; m_s[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(out_valid == 1'b0, "R1", 72'(out_valid), 72'(0));
        chk(in_ready == 1'b1, "R1", 72'(in_ready), 72'(1));
        // R1: table empty, segment misses
        send(1'b0, 4'd3, 32'h100, 32'h200, 1'b1);
        send(1'b1, 4'd7, 32'h300, 32'h400, 1'b0);
        // Directed entries
        cfg(4'd3, 1'b1, 32'h1000_0000, 32'h5000_0000);
        send(1'b0, 4'd3, 32'hAAAA, 32'h1000_0005, 1'b1);  // R2: D+5 -> S+5
        send(1'b0, 4'd3, 32'hAAAB, 32'h1000_0009, 1'b0);  // R3: untouched
        send(1'b1, 4'd3, 32'h5000_0011, 32'hAAAC, 1'b1);  // R4: S+0x11 -> D+0x11
        send(1'b1, 4'd3, 32'h5000_0012, 32'hAAAD, 1'b0);  // R4
        send(1'b0, 4'd9, 32'h1, 32'h2, 1'b1);              // R5: invalid entry
        cfg(4'd2, 1'b1, 32'hFFFF_FFF0, 32'h0000_0010);    // R6 wrap
        send(1'b0, 4'd2, 32'h77, 32'h0000_0010, 1'b1);
        send(1'b1, 4'd2, 32'h0000_0030, 32'h78, 1'b1);
        @(negedge clk);
        @(posedge clk); #1;
        // R6: explicit wrap value on the last result if still present
        // R8: write and lookup of entry 5 in the same cycle
        repeat (2) @(posedge clk);
        #1;
        cfg_we = 1'b1; cfg_idx = 4'd5; cfg_set = 1'b1; cfg_sw_isn = 32'h20; cfg_srv_isn = 32'h820;
        in_valid = 1'b1; in_dir = 1'b0; in_conn = 4'd5; in_seq = 32'h9; in_ack = 32'h25; in_ack_flag = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8", 72'(in_ready), 72'(1));
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        send(1'b0, 4'd5, 32'h9, 32'h25, 1'b1);  // now hits
        // R8: clearing an entry in the same cycle as a lookup
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_idx = 4'd3; cfg_set = 1'b0;
        in_valid = 1'b1; in_dir = 1'b1; in_conn = 4'd3; in_seq = 32'h5000_0040; in_ack = 32'h1; in_ack_flag = 1'b0;
        @(posedge clk); #1;
        cfg_we = 1'b0; in_valid = 1'b0;
        send(1'b1, 4'd3, 32'h5000_0041, 32'h1, 1'b0);  // now misses
        // Random phase with stalls and interleaved writes
        rdy_rand = 1'b1;
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 10 == 0)
                cfg(4'($urandom), ($urandom % 5 != 0), $urandom, $urandom);
            send(1'($urandom), 4'($urandom), $urandom, $urandom, 1'($urandom));
        end
        rdy_rand = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        // R7: every taken segment came out
        chk(q.size() == 0, "R7", 72'(q.size()), 72'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule